// File: doc/BRIEF.md
# Board Interrupt and Card-Status Controller

This block gathers sixteen external interrupt inputs into a single summary interrupt for a host processor. Each input has an enable bit. While an input is high and its enable bit is set, the matching pending bit is latched and stays set until the host rewrites the pending register. The summary output is raised whenever any pending bit is also enabled. Enable and pending writes pass through a fixed writable-bit mask, so several bit positions can never be enabled or left pending.

Two of the inputs also report card presence. Input 9 belongs to card slot 0 and input 13 to card slot 1. Each slot has a status/control register with an active-low card-detect bit that follows the inverse of its input. The host can change only the slot's power/reset control field. Three plain scratch registers hold LED data and LED control.

The host reaches all registers through a single-cycle read/write port. Read data is combinational from the address. Writes take effect at the next clock edge. Accesses to offsets that are not decoded give an error pulse.

Top module: `irq_board_ctrl`

## Requirements
- R1: After reset, the enable and pending registers read 0, each card slot register reads 0x420, the LED registers read 0, and `irq_out` and `err_pulse` are 0.
- R2: A write to the enable register (offset 0xC0) or the pending register (offset 0xD0) stores the write data ANDed with 0x000FEEFF. Bits 8, 12 and 20 to 31 therefore always read back 0.
- R3: At each clock edge, every input that is high and whose enable bit is 1 sets its pending bit. An input whose enable bit is 0 leaves its pending bit unchanged.
- R4: Once set, a pending bit stays set after its input falls. Only a host write to offset 0xD0 changes it, and that write replaces the whole register; it is not a write-1-to-clear. In a cycle with a pending write, the write takes priority over input latching.
- R5: `irq_out` is a register equal to the OR of (pending AND enable). It reflects an input sample, a pending write or an enable write at the same clock edge that updates those registers.
- R6: Bit 5 of card slot 0 (offset 0xE0) reads as the inverse of input 9, sampled at the previous clock edge. Bit 5 of card slot 1 (offset 0xE4) does the same for input 13.
- R7: A host write to a card slot register changes only bits [4:0]. Bit 10 (ready) stays 1, bit 5 keeps following its input, and all other bits stay 0.
- R8: The LED data registers at 0x10 and 0x14 and the LED control register at 0x40 are full 32-bit read/write scratch registers.
- R9: Offset 0x00 reads the level of all sixteen inputs registered at the previous clock edge, in bits [15:0]. A write to 0x00 is ignored and raises no error.
- R10: Any access to an undefined offset reads 0 and is ignored on write. It raises `err_pulse` for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 16 | External interrupt levels, active high |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for `req_addr`, combinational |
| irq_out | output | 1 | Summary interrupt, registered |
| err_pulse | output | 1 | One-cycle flag after an access to an undefined offset |

## Verification
On every cycle, the assertions check the following:
- the masked-bit invariant on enable and pending;
- that enabled high inputs are latched;
- that pending bits stay set when no pending write is made;
- that the summary output agrees with pending AND enable;
- that the card-detect bits follow their inputs;
- that the error flag only appears after an access.

Only the bench scenarios show the effects seen through the register port. These are the exact read-back values after masked writes, the whole-register replacement on a pending write, the summary output rising after an enable write alone, the protected upper bits of the slot registers, the LED scratch storage, and that writes to undefined offsets or to the input-level register leave every register unchanged.

// File: rtl/irq_board_pkg.sv
package irq_board_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_IRQ = 16;

    localparam logic [DATA_W-1:0] IRQ_WR_MASK = 32'h000F_EEFF;

    localparam int SLOT_CTRL_W  = 5;
    localparam int SLOT_NCD_BIT = 5;
    localparam int SLOT_RDY_BIT = 10;
    localparam int SLOT0_IRQ    = 9;
    localparam int SLOT1_IRQ    = 13;
    localparam int NUM_SLOT     = 2;
    localparam int NUM_SCRATCH  = 3;

    localparam logic [ADDR_W-1:0] OFF_RAW    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LED1   = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_LED2   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_LEDCTL = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_ENA    = 8'hC0;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'hD0;
    localparam logic [ADDR_W-1:0] OFF_SLOT0  = 8'hE0;
    localparam logic [ADDR_W-1:0] OFF_SLOT1  = 8'hE4;

    typedef enum logic [3:0] {
        SEL_RAW,
        SEL_LED1,
        SEL_LED2,
        SEL_LEDCTL,
        SEL_ENA,
        SEL_PEND,
        SEL_SLOT0,
        SEL_SLOT1,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_RAW:    return SEL_RAW;
            OFF_LED1:   return SEL_LED1;
            OFF_LED2:   return SEL_LED2;
            OFF_LEDCTL: return SEL_LEDCTL;
            OFF_ENA:    return SEL_ENA;
            OFF_PEND:   return SEL_PEND;
            OFF_SLOT0:  return SEL_SLOT0;
            OFF_SLOT1:  return SEL_SLOT1;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
    parameter int                NUM_IRQ = 16,
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h000F_EEFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               en_wr,
    input  logic               pend_wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  en_q,
    output logic [DATA_W-1:0]  pend_q,
    output logic [NUM_IRQ-1:0] raw_q,
    output logic               irq_out
);

    localparam int PAD_W = DATA_W - NUM_IRQ;

    logic [DATA_W-1:0] lvl_ext;
    logic [DATA_W-1:0] en_d;
    logic [DATA_W-1:0] pend_d;

    assign lvl_ext = {{PAD_W{1'b0}}, irq_in};

    always_comb begin
        en_d   = en_wr ? (wdata & WR_MASK) : en_q;
        pend_d = pend_wr ? (wdata & WR_MASK) : (pend_q | (lvl_ext & en_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            pend_q  <= '0;
            raw_q   <= '0;
            irq_out <= 1'b0;
        end else begin
            en_q    <= en_d;
            pend_q  <= pend_d;
            raw_q   <= irq_in;
            irq_out <= |(pend_d & en_d);
        end
    end

endmodule

// File: rtl/card_slot_reg.sv
module card_slot_reg #(
    parameter int DATA_W  = 32,
    parameter int CTRL_W  = 5,
    parameter int NCD_BIT = 5,
    parameter int RDY_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_in,
    input  logic              wr,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [DATA_W-1:0] val
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              ncd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ncd_q  <= 1'b1;
        end else begin
            ncd_q <= ~det_in;
            if (wr) begin
                ctrl_q <= ctrl_in;
            end
        end
    end

    always_comb begin
        val                 = '0;
        val[CTRL_W-1:0]     = ctrl_q;
        val[NCD_BIT]        = ncd_q;
        val[RDY_BIT]        = 1'b1;
    end

endmodule

// File: rtl/scratch_reg.sv
module scratch_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
        end else if (wr) begin
            val <= wdata;
        end
    end

endmodule

// File: rtl/irq_board_ctrl.sv
module irq_board_ctrl
    import irq_board_pkg::*;
#(
    parameter int NUM_IRQ = irq_board_pkg::NUM_IRQ,
    parameter int DATA_W  = irq_board_pkg::DATA_W,
    parameter int ADDR_W  = irq_board_pkg::ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               irq_out,
    output logic               err_pulse
);

    localparam int PAD_W = DATA_W - NUM_IRQ;

    reg_sel_e          sel;
    logic              wr_en;
    logic [DATA_W-1:0] en_w;
    logic [DATA_W-1:0] pend_w;
    logic [NUM_IRQ-1:0] raw_w;
    logic [DATA_W-1:0] slot_w    [NUM_SLOT];
    logic [DATA_W-1:0] scratch_w [NUM_SCRATCH];

    assign sel   = decode_addr(req_addr);
    assign wr_en = req_valid & req_write;

    irq_pend_unit #(
        .NUM_IRQ (NUM_IRQ),
        .DATA_W  (DATA_W),
        .WR_MASK (IRQ_WR_MASK)
    ) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .en_wr   (wr_en && (sel == SEL_ENA)),
        .pend_wr (wr_en && (sel == SEL_PEND)),
        .wdata   (req_wdata),
        .en_q    (en_w),
        .pend_q  (pend_w),
        .raw_q   (raw_w),
        .irq_out (irq_out)
    );

    for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
        localparam int       DET_IDX = (g == 0) ? SLOT0_IRQ : SLOT1_IRQ;
        localparam reg_sel_e MY_SEL  = (g == 0) ? SEL_SLOT0 : SEL_SLOT1;
        card_slot_reg #(
            .DATA_W  (DATA_W),
            .CTRL_W  (SLOT_CTRL_W),
            .NCD_BIT (SLOT_NCD_BIT),
            .RDY_BIT (SLOT_RDY_BIT)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .det_in  (irq_in[DET_IDX]),
            .wr      (wr_en && (sel == MY_SEL)),
            .ctrl_in (req_wdata[SLOT_CTRL_W-1:0]),
            .val     (slot_w[g])
        );
    end

    for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scratch
        localparam reg_sel_e MY_SEL = (g == 0) ? SEL_LED1 :
                                      (g == 1) ? SEL_LED2 : SEL_LEDCTL;
        scratch_reg #(
            .DATA_W (DATA_W)
        ) u_scr (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr_en && (sel == MY_SEL)),
            .wdata (req_wdata),
            .val   (scratch_w[g])
        );
    end

    always_comb begin
        unique case (sel)
            SEL_RAW:    rsp_rdata = {{PAD_W{1'b0}}, raw_w};
            SEL_LED1:   rsp_rdata = scratch_w[0];
            SEL_LED2:   rsp_rdata = scratch_w[1];
            SEL_LEDCTL: rsp_rdata = scratch_w[2];
            SEL_ENA:    rsp_rdata = en_w;
            SEL_PEND:   rsp_rdata = pend_w;
            SEL_SLOT0:  rsp_rdata = slot_w[0];
            SEL_SLOT1:  rsp_rdata = slot_w[1];
            default:    rsp_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= req_valid && (sel == SEL_NONE);
        end
    end

endmodule

// File: rtl/irq_board_chk.sv
module irq_board_chk
    import irq_board_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               irq_out,
    input logic               err_pulse,
    input logic [DATA_W-1:0]  en_w,
    input logic [DATA_W-1:0]  pend_w,
    input logic               ncd0,
    input logic               ncd1
);

    logic [DATA_W-1:0] lvl_en;
    logic              pend_wr_now;

    assign lvl_en      = {{(DATA_W-NUM_IRQ){1'b0}}, irq_in} & en_w;
    assign pend_wr_now = req_valid && req_write && (req_addr == OFF_PEND);

    AST_MASKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_w & ~IRQ_WR_MASK) == '0) && ((pend_w & ~IRQ_WR_MASK) == '0)); // R2

    AST_LATCH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr_now |=> ((pend_w & $past(lvl_en)) == $past(lvl_en))); // R3

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_wr_now |=> ((pend_w & $past(pend_w)) == $past(pend_w))); // R4

    AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(pend_w & en_w))); // R5

    AST_DETECT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ncd0 == !$past(irq_in[SLOT0_IRQ]))); // R6

    AST_DETECT_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ncd1 == !$past(irq_in[SLOT1_IRQ]))); // R6

    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid)); // R10

endmodule

bind irq_board_ctrl irq_board_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .irq_out   (irq_out),
    .err_pulse (err_pulse),
    .en_w      (en_w),
    .pend_w    (pend_w),
    .ncd0      (slot_w[0][irq_board_pkg::SLOT_NCD_BIT]),
    .ncd1      (slot_w[1][irq_board_pkg::SLOT_NCD_BIT])
);

// File: tb/irq_board_ctrl_bench.sv
`timescale 1ns/1ps
module irq_board_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        irq_out;
    logic        err_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];

    always #10 clk = ~clk;

    irq_board_ctrl u_irq_board_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .irq_out   (irq_out),
        .err_pulse (err_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard between edges while a read is presented
    always @(negedge clk) begin
        if (rst_n && req_valid && !req_write) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL scoreboard empty addr=0x%02h actual=0x%08h expected=none",
                         req_addr, rsp_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk({it.tag, $sformatf(" read 0x%02h", it.addr)}, rsp_rdata, it.exp);
            end
        end
    end

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #2;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        @(posedge clk); #2;
        exp_q.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic set_irq(input logic [15:0] v);
        @(posedge clk); #2;
        irq_in = v;
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        chk("R1 err_pulse", {31'b0, err_pulse}, 32'h0);
        host_rd(8'hC0, 32'h0, "R1 enable");
        host_rd(8'hD0, 32'h0, "R1 pending");
        host_rd(8'hE0, 32'h420, "R1 slot0");
        host_rd(8'hE4, 32'h420, "R1 slot1");
        host_rd(8'h10, 32'h0, "R1 led1");

        // R2 masked enable write
        host_wr(8'hC0, 32'hFFFF_FFFF);
        chk("R10 no err on legal write", {31'b0, err_pulse}, 32'h0);
        host_rd(8'hC0, 32'h000F_EEFF, "R2 enable mask");

        // R3/R5 latch on enabled high input, irq_out at same edge
        set_irq(16'h0001);
        chk("R5 irq_out after input", {31'b0, irq_out}, 32'h1);
        host_rd(8'h00, 32'h0001, "R9 raw level");
        host_rd(8'hD0, 32'h0001, "R3 pending set");

        // R4 sticky after input falls
        set_irq(16'h0000);
        chk("R4 irq_out held", {31'b0, irq_out}, 32'h1);
        host_rd(8'hD0, 32'h0001, "R4 pending sticky");
        host_rd(8'h00, 32'h0000, "R9 raw low");

        // R4/R5 pending overwrite clears
        host_wr(8'hD0, 32'h0);
        chk("R5 irq_out after pend write", {31'b0, irq_out}, 32'h0);
        host_rd(8'hD0, 32'h0, "R4 pending cleared");

        // R3 inputs 8 and 12 cannot be enabled
        set_irq(16'h1100);
        chk("R3 irq_out masked inputs", {31'b0, irq_out}, 32'h0);
        host_rd(8'hD0, 32'h0, "R3 masked inputs not latched");
        set_irq(16'h0000);

        // R3 selective enable
        host_wr(8'hC0, 32'h1);
        set_irq(16'h0003);
        host_rd(8'hD0, 32'h1, "R3 only enabled bit latched");
        set_irq(16'h0000);
        host_wr(8'hD0, 32'h0);

        // R2/R4/R5 pending write replaces, enable write re-evaluates
        host_wr(8'hC0, 32'h0);
        host_wr(8'hD0, 32'hFFFF_FFFF);
        chk("R5 irq_out pend w/o enable", {31'b0, irq_out}, 32'h0);
        host_rd(8'hD0, 32'h000F_EEFF, "R2 pending mask");
        host_wr(8'hC0, 32'h0001_0000);
        chk("R5 irq_out after enable write", {31'b0, irq_out}, 32'h1);
        host_wr(8'hD0, 32'h0000_0004);
        chk("R5 irq_out after replace", {31'b0, irq_out}, 32'h0);
        host_rd(8'hD0, 32'h0000_0004, "R4 pending replaced");
        host_wr(8'hD0, 32'h0);

        // R6 card detect
        set_irq(16'h0200);
        host_rd(8'hE0, 32'h400, "R6 slot0 detected");
        host_rd(8'hE4, 32'h420, "R6 slot1 empty");
        set_irq(16'h2000);
        host_rd(8'hE4, 32'h400, "R6 slot1 detected");
        host_rd(8'hE0, 32'h420, "R6 slot0 empty");
        set_irq(16'h0000);
        host_rd(8'hE4, 32'h420, "R6 slot1 removed");

        // R7 slot writes limited to [4:0]
        host_wr(8'hE0, 32'hFFFF_FFFF);
        host_rd(8'hE0, 32'h43F, "R7 slot0 ctrl only");
        host_rd(8'hE4, 32'h420, "R7 slot1 untouched");
        host_wr(8'hE4, 32'h0000_0015);
        host_rd(8'hE4, 32'h435, "R7 slot1 ctrl");
        host_wr(8'hE0, 32'h0);
        host_rd(8'hE0, 32'h420, "R7 slot0 cleared");

        // R8 LED scratch
        host_wr(8'h10, 32'hA5A5_0001);
        host_wr(8'h14, 32'h5A5A_0002);
        host_wr(8'h40, 32'hDEAD_BEEF);
        host_rd(8'h10, 32'hA5A5_0001, "R8 led1");
        host_rd(8'h14, 32'h5A5A_0002, "R8 led2");
        host_rd(8'h40, 32'hDEAD_BEEF, "R8 ledctl");

        // R9 raw register write ignored
        host_wr(8'h00, 32'hFFFF_FFFF);
        chk("R9 no err on raw write", {31'b0, err_pulse}, 32'h0);
        host_rd(8'h00, 32'h0, "R9 raw write ignored");

        // R10 undefined offset
        host_wr(8'h44, 32'h1234_5678);
        chk("R10 err pulse", {31'b0, err_pulse}, 32'h1);
        @(posedge clk); #2;
        chk("R10 err one cycle", {31'b0, err_pulse}, 32'h0);
        host_rd(8'h44, 32'h0, "R10 undefined read");
        host_rd(8'h40, 32'hDEAD_BEEF, "R10 write ignored ledctl");
        host_rd(8'h10, 32'hA5A5_0001, "R10 write ignored led1");
        host_wr(8'hD4, 32'hFFFF_FFFF);
        host_rd(8'hD0, 32'h0, "R10 no pending alias");
        host_rd(8'hC0, 32'h0001_0000, "R10 no enable alias");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule